// File: doc/BRIEF.md
# Relocatable Index/Data Configuration Port

This block is the host-facing entry to a chip's global configuration space. It sits on a plain byte-wide host I/O bus made of a 12-bit address, read and write strobes and 8-bit data. It answers at two adjacent I/O addresses. The even address is the index port. The host writes a register number there and can read it back. The odd address is the data port, which reaches whichever register the index selects.

The pair of ports can be moved anywhere on an even 12-bit boundary. Relocation takes two steps. Writing the low-byte relocation register only stages the new low address bits. The decode base switches over when the high-byte relocation register is written, and it then combines the staged low byte with the new high bits. At hard reset the base comes from a strap pin. A host-triggered soft reset clears the logical device number register but leaves the relocation state alone. A chip-select output flags every bus cycle aimed at either port.

Top module: `cfg_port_decoder`

## Requirements
- R1: A hard reset happens while `por_n` or `ext_rst_n` is low at a clock edge. It sets the base to 0x02E when `strap_mode` is 0 and to 0x04E when it is 1. It sets the staged low byte to the low byte of that base, the high-byte register to 0x00, the index to 0x00 and the logical device number to 0x00.
- R2: `cs` is high exactly when all 12 bits of `io_addr` equal the live base or the live base plus one, independent of the strobes.
- R3: A write to base+0 loads the index from `io_wdata` at that clock edge. A read of base+0 returns the current index.
- R4: A data-port write with index 0x26 stages bits 7..1 of the data as address bits A7..A1. Reading index 0x26 returns the staged byte with bit 0 always 0. The live base is not changed.
- R5: A data-port write with index 0x27 stores bits 3..0 as A11..A8. From the next cycle the live base is {A11..A8, staged low byte}. Reading index 0x27 returns bits 7..4 as 0.
- R6: Index 0x07 is the logical device number. It is readable and writable through the data port.
- R7: Writing data with bit 0 set to index 0x02 raises a one-cycle internal soft-reset pulse in the following cycle. That pulse clears the logical device number at the next edge and overrides a same-edge write to it. Writing with bit 0 clear does nothing.
- R8: A soft reset leaves the index, the staged low byte, the high-byte register and the live base unchanged.
- R9: Data-port reads of index 0x02 and of any index other than 0x07, 0x26 and 0x27 return 0x00. Writes to those indices change no readable register.
- R10: `io_rdata` is 0x00 whenever `io_rd` is low or `cs` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, sampled on clk |
| ext_rst_n | input | 1 | External reset-out, active low, sampled on clk |
| strap_mode | input | 1 | Strap that selects the base loaded at hard reset |
| io_addr | input | 12 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one per clock cycle |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, 0x00 when not addressed |
| cs | output | 1 | High when io_addr hits the index or data port |

## Verification
`cs` and `io_rdata` are combinational from the present address, strobe and register state, so they are due in the same cycle as the stimulus. The bench samples them one time unit after it drives the inputs at the falling edge. Index loads, relocation-register writes and base commits land at the next rising edge and show up in the cycle after the write. The soft-reset pulse adds one more register stage, so the logical device number reads zero two edges after the control write. The reference model updates its integer state at each rising edge with exactly these delays and is compared against both outputs in every cycle, including cycles spent in reset.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

   localparam int unsigned IDX_W = 8;

   localparam logic [IDX_W-1:0] IDX_CTRL    = 8'h02;
   localparam logic [IDX_W-1:0] IDX_LDN     = 8'h07;
   localparam logic [IDX_W-1:0] IDX_BASE_LO = 8'h26;
   localparam logic [IDX_W-1:0] IDX_BASE_HI = 8'h27;

   typedef struct packed {
      logic wr_idx;
      logic wr_dat;
      logic rd_idx;
      logic rd_dat;
   } port_acc_t;

endpackage

// File: rtl/cfgp_addr_match.sv
module cfgp_addr_match
   import cfgp_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned NPORTS = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic              wr,
   input  logic              rd,
   output logic              hit_any,
   output port_acc_t         acc
);

   localparam int unsigned SEL_IDX = 0;
   localparam int unsigned SEL_DAT = 1;

   initial begin
      if (NPORTS != 2) $error("cfgp_addr_match: exactly two ports are supported");
   end

   logic [NPORTS-1:0] hit;

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      localparam logic [ADDR_W-1:0] OFS = ADDR_W'(p);
      assign hit[p] = (addr == (base + OFS));
   end

   assign hit_any    = |hit;
   assign acc.wr_idx = wr & hit[SEL_IDX];
   assign acc.wr_dat = wr & hit[SEL_DAT];
   assign acc.rd_idx = rd & hit[SEL_IDX];
   assign acc.rd_dat = rd & hit[SEL_DAT];

   // R2: the two port addresses never overlap
   always_comb begin
      if (!$isunknown(hit)) begin
         p_port_hits_exclusive_r2: assert ($onehot0(hit));
      end
   end

endmodule

// File: rtl/cfgp_regs.sv
module cfgp_regs
   import cfgp_pkg::*;
#(
   parameter int unsigned         ADDR_W     = 12,
   parameter logic [ADDR_W-1:0]   BASE_STRAP0 = 12'h02E,
   parameter logic [ADDR_W-1:0]   BASE_STRAP1 = 12'h04E
) (
   input  logic              clk,
   input  logic              hard_rst,
   input  logic              strap_mode,
   input  port_acc_t         acc,
   input  logic [IDX_W-1:0]  wdata,
   output logic [IDX_W-1:0]  idx,
   output logic [IDX_W-1:0]  dat_rd,
   output logic [ADDR_W-1:0] base
);

   localparam int unsigned HI_W = ADDR_W - IDX_W;

   initial begin
      if (HI_W < 1 || HI_W > IDX_W) $error("cfgp_regs: ADDR_W must lie in 9..16");
      if (BASE_STRAP0[0] || BASE_STRAP1[0]) $error("cfgp_regs: strap bases must be even");
   end

   logic [IDX_W-1:0] lo_stage;
   logic [HI_W-1:0]  hi_reg;
   logic [IDX_W-1:0] ldn;
   logic             soft_q;
   logic [ADDR_W-1:0] strap_base;

   logic wr_ctrl, wr_ldn, wr_lo, wr_hi;

   assign strap_base = strap_mode ? BASE_STRAP1 : BASE_STRAP0;
   assign wr_ctrl    = acc.wr_dat && (idx == IDX_CTRL);
   assign wr_ldn     = acc.wr_dat && (idx == IDX_LDN);
   assign wr_lo      = acc.wr_dat && (idx == IDX_BASE_LO);
   assign wr_hi      = acc.wr_dat && (idx == IDX_BASE_HI);

   always_ff @(posedge clk) begin
      if (hard_rst) begin
         idx      <= '0;
         lo_stage <= strap_base[IDX_W-1:0];
         hi_reg   <= '0;
         base     <= strap_base;
         ldn      <= '0;
         soft_q   <= 1'b0;
      end else begin
         soft_q <= wr_ctrl & wdata[0];
         if (acc.wr_idx) idx <= wdata;
         if (wr_lo) lo_stage <= {wdata[IDX_W-1:1], 1'b0};
         if (wr_hi) begin
            hi_reg <= wdata[HI_W-1:0];
            base   <= {wdata[HI_W-1:0], lo_stage};
         end
         if (soft_q)      ldn <= '0;
         else if (wr_ldn) ldn <= wdata;
      end
   end

   always_comb begin
      unique case (idx)
         IDX_BASE_LO: dat_rd = lo_stage;
         IDX_BASE_HI: dat_rd = IDX_W'(hi_reg);
         IDX_LDN:     dat_rd = ldn;
         default:     dat_rd = '0;
      endcase
   end

   // R5: a high-byte write commits staged low byte plus new high bits
   p_base_commit_r5: assert property (@(posedge clk) disable iff (hard_rst)
      wr_hi |=> base == {$past(wdata[HI_W-1:0]), $past(lo_stage)});

   // R4, R8: nothing but a high-byte write moves the base
   p_base_hold_r8: assert property (@(posedge clk) disable iff (hard_rst)
      !wr_hi |=> $stable(base));

   // R7: the soft pulse only follows a control write with bit 0 set
   p_soft_source_r7: assert property (@(posedge clk) disable iff (hard_rst)
      soft_q |-> $past(wr_ctrl && wdata[0]));

   // R7: the pulse clears the device number at the next edge
   p_soft_clears_ldn_r7: assert property (@(posedge clk) disable iff (hard_rst)
      soft_q |=> ldn == '0);

   // R8: soft reset keeps the staged relocation byte
   p_soft_keeps_lo_r8: assert property (@(posedge clk) disable iff (hard_rst)
      (soft_q && !wr_lo) |=> $stable(lo_stage));

endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
   import cfgp_pkg::*;
#(
   parameter int unsigned       ADDR_W      = 12,
   parameter logic [ADDR_W-1:0] BASE_STRAP0 = 12'h02E,
   parameter logic [ADDR_W-1:0] BASE_STRAP1 = 12'h04E
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              ext_rst_n,
   input  logic              strap_mode,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [IDX_W-1:0]  io_wdata,
   output logic [IDX_W-1:0]  io_rdata,
   output logic              cs
);

   localparam int unsigned HI_W = ADDR_W - IDX_W;

   logic              hard_rst;
   port_acc_t         acc;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  dat_rd;
   logic [ADDR_W-1:0] base;

   assign hard_rst = !por_n || !ext_rst_n;

   cfgp_addr_match #(
      .ADDR_W (ADDR_W),
      .NPORTS (2)
   ) u_match (
      .addr    (io_addr),
      .base    (base),
      .wr      (io_wr),
      .rd      (io_rd),
      .hit_any (cs),
      .acc     (acc)
   );

   cfgp_regs #(
      .ADDR_W      (ADDR_W),
      .BASE_STRAP0 (BASE_STRAP0),
      .BASE_STRAP1 (BASE_STRAP1)
   ) u_regs (
      .clk        (clk),
      .hard_rst   (hard_rst),
      .strap_mode (strap_mode),
      .acc        (acc),
      .wdata      (io_wdata),
      .idx        (idx),
      .dat_rd     (dat_rd),
      .base       (base)
   );

   always_comb begin
      if (acc.rd_idx)      io_rdata = idx;
      else if (acc.rd_dat) io_rdata = dat_rd;
      else                 io_rdata = '0;
   end

   // R4: the low relocation byte never reads back odd
   p_lo_reads_even_r4: assert property (@(posedge clk) disable iff (hard_rst)
      (acc.rd_dat && idx == IDX_BASE_LO) |-> io_rdata[0] == 1'b0);

   // R5: unused upper bits of the high relocation byte read zero
   p_hi_upper_zero_r5: assert property (@(posedge clk) disable iff (hard_rst)
      (acc.rd_dat && idx == IDX_BASE_HI) |-> io_rdata[IDX_W-1:HI_W] == '0);

   // R10: bus stays quiet unless a port is being read
   p_quiet_bus_r10: assert property (@(posedge clk) disable iff (hard_rst)
      !(io_rd && cs) |-> io_rdata == '0);

endmodule

// File: tb/sim_cfg_port_decoder.sv
module sim_cfg_port_decoder;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        ext_rst_n = 1'b1;
   logic        strap_mode = 1'b0;
   logic [11:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        cs;

   int    n_checks = 0;
   int    n_errors = 0;
   string tag = "R1";
   bit    done = 1'b0;

   cfg_port_decoder u0 (
      .clk        (clk),
      .por_n      (por_n),
      .ext_rst_n  (ext_rst_n),
      .strap_mode (strap_mode),
      .io_addr    (io_addr),
      .io_wr      (io_wr),
      .io_rd      (io_rd),
      .io_wdata   (io_wdata),
      .io_rdata   (io_rdata),
      .cs         (cs)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference state
   int m_idx, m_lo, m_hi, m_base, m_ldn;
   bit m_soft;

   function automatic int m_reg();
      case (m_idx)
         'h26:    return m_lo;
         'h27:    return m_hi;
         'h07:    return m_ldn;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      int a;
      int d;
      bit ns;
      a  = int'(io_addr);
      d  = int'(io_wdata);
      ns = 1'b0;
      if (!por_n || !ext_rst_n) begin
         m_base = strap_mode ? 'h04E : 'h02E;
         m_lo   = m_base & 'hFF;
         m_hi   = 0;
         m_idx  = 0;
         m_ldn  = 0;
         m_soft = 1'b0;
      end else begin
         if (io_wr && a == m_base) m_idx = d;
         else if (io_wr && a == m_base + 1) begin
            case (m_idx)
               'h02: ns = d[0];
               'h07: m_ldn = d;
               'h26: m_lo = d & 'hFE;
               'h27: begin
                  m_hi   = d & 'h0F;
                  m_base = (m_hi << 8) | m_lo;
               end
               default: ;
            endcase
         end
         if (m_soft) m_ldn = 0;
         m_soft = ns;
      end
   end

   task automatic compare();
      int a;
      int exp_rd;
      bit exp_cs;
      a      = int'(io_addr);
      exp_cs = (a == m_base) || (a == m_base + 1);
      exp_rd = 0;
      if (io_rd && a == m_base)          exp_rd = m_idx;
      else if (io_rd && a == m_base + 1) exp_rd = m_reg();
      n_checks++;
      if (cs !== exp_cs) begin
         n_errors++;
         $display("FAIL %s cs addr=%03h actual=%b expected=%b", tag, io_addr, cs, exp_cs);
      end
      n_checks++;
      if (io_rdata !== 8'(exp_rd)) begin
         n_errors++;
         $display("FAIL %s rdata addr=%03h actual=%02h expected=%02h", tag, io_addr, io_rdata, 8'(exp_rd));
      end
   endtask

   task automatic cyc(input int a, input bit w, input bit r, input int d);
      @(negedge clk);
      io_addr  = 12'(a);
      io_wr    = w;
      io_rd    = r;
      io_wdata = 8'(d);
      #1;
      compare();
   endtask

   task automatic wr_io(input int a, input int d); cyc(a, 1'b1, 1'b0, d); endtask
   task automatic rd_io(input int a);              cyc(a, 1'b0, 1'b1, 0); endtask
   task automatic idle();                          cyc(0, 1'b0, 1'b0, 0); endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R1: power-on with strap low
      tag = "R1";
      for (int i = 0; i < 3; i++) idle();
      por_n = 1'b1;
      idle();
      rd_io('h02E);
      wr_io('h02E, 'h27);
      rd_io('h02F);
      wr_io('h02E, 'h26);
      rd_io('h02F);
      // R3: index readback
      tag = "R3";
      wr_io('h02E, 'h5C);
      rd_io('h02E);
      wr_io('h02E, 'h07);
      rd_io('h02E);
      // R2: address sweep, all 12 bits compared
      tag = "R2";
      for (int i = 0; i < 48; i++) rd_io((i * 173 + 'h021) & 'hFFF);
      rd_io('h12E); rd_io('h82F); rd_io('h02D); rd_io('h030); rd_io('h02F);
      cyc('h02F, 1'b0, 1'b0, 0);
      // R6: device number read/write
      tag = "R6";
      wr_io('h02E, 'h07);
      wr_io('h02F, 'h5A);
      rd_io('h02F);
      wr_io('h02F, 'hC3);
      rd_io('h02F);
      // R4: stage low byte only
      tag = "R4";
      wr_io('h02E, 'h26);
      wr_io('h02F, 'h91);
      rd_io('h02F);
      rd_io('h090);
      rd_io('h02E);
      // R5: commit via high byte
      tag = "R5";
      wr_io('h02E, 'h27);
      wr_io('h02F, 'hF3);
      rd_io('h390);
      rd_io('h391);
      rd_io('h02E);
      rd_io('h02F);
      // R7: soft reset clears device number
      tag = "R7";
      wr_io('h390, 'h07);
      wr_io('h391, 'h33);
      wr_io('h390, 'h02);
      wr_io('h391, 'h01);
      idle();
      wr_io('h390, 'h07);
      rd_io('h391);
      wr_io('h391, 'h44);
      wr_io('h390, 'h02);
      wr_io('h391, 'hFE);
      idle();
      wr_io('h390, 'h07);
      rd_io('h391);
      // R8: relocation state survives soft reset
      tag = "R8";
      wr_io('h390, 'h02);
      wr_io('h391, 'h01);
      rd_io('h390);
      rd_io('h391);
      wr_io('h390, 'h26);
      rd_io('h391);
      wr_io('h390, 'h27);
      rd_io('h391);
      // R9: control and reserved indices read zero, writes ignored
      tag = "R9";
      wr_io('h390, 'h02);
      rd_io('h391);
      wr_io('h390, 'h17);
      wr_io('h391, 'hFF);
      rd_io('h391);
      wr_io('h390, 'h03);
      wr_io('h391, 'hA5);
      rd_io('h391);
      wr_io('h390, 'hEE);
      rd_io('h391);
      wr_io('h390, 'h07);
      rd_io('h391);
      wr_io('h390, 'h26);
      rd_io('h391);
      // R10: no read or no select gives zero data
      tag = "R10";
      cyc('h391, 1'b1, 1'b0, 'h26);
      cyc('h390, 1'b0, 1'b0, 0);
      rd_io('h392);
      rd_io('h38F);
      // R1: external reset with strap high
      tag = "R1";
      strap_mode = 1'b1;
      ext_rst_n  = 1'b0;
      for (int i = 0; i < 3; i++) idle();
      ext_rst_n = 1'b1;
      idle();
      rd_io('h04E);
      rd_io('h390);
      wr_io('h04E, 'h27);
      rd_io('h04F);
      wr_io('h04E, 'h26);
      rd_io('h04F);
      wr_io('h04E, 'h07);
      rd_io('h04F);
      idle();
      finish_run();
   end

endmodule